// File: doc/BRIEF.md
# Expansion RAM Block Mover

This block copies runs of bytes between the host system's RAM and a private expansion RAM. The host CPU programs it through an eleven-byte register window. The window holds a host start address, an expansion start address with a bank byte, a byte count, an interrupt enable and an address-hold control. A command byte then launches the job. The job starts either at once or after the CPU writes to a fixed trigger address on its own bus. The block snoops that bus for the trigger write.

While a job runs, the block raises a DMA request that stalls the CPU and drives both memory buses. It moves one byte per clock. The job can copy in either direction, swap the contents of the two windows, or compare them without writing anything. Both memories are taken to answer reads in the same cycle. At the end the block drops the request, clears the execute bit, sets an end-of-block flag and, if enabled, raises its interrupt line.

Top module: `xram_dma`

## Requirements
- R1: After reset every register reads 0x00, and `dma_req` and `irq` are low.
- R2: Offsets 2/3 (host address low/high), 4/5 (expansion address low/high), 6 (bank), 7/8 (length low/high), 9 (interrupt enable) and 10 (address hold) read back what was written. A command write at offset 1 with bit 7 clear is stored and starts nothing.
- R3: A command write with bit 7 (execute) and bit 4 (start now) both set raises `dma_req` from the next cycle for exactly N cycles, where N is the programmed length. The length register counts down by one per byte and reads 1 at the end.
- R4: With bit 7 set and bit 4 clear, the job waits. A snooped bus write to address FF00h starts it. Snooped writes to any other address leave it waiting.
- R5: Command bits 1:0 = 00 copy host RAM into expansion RAM, and 01 copy expansion RAM into host RAM. Neither memory is written outside a job.
- R6: Type 10 exchanges the bytes of the two windows.
- R7: Type 11 writes neither memory. It sets status bit 5 if any byte pair differs.
- R8: After each byte both addresses advance by one. Address-hold bit 7 keeps the host address fixed, and bit 6 keeps the expansion address fixed.
- R9: A carry out of the 16-bit expansion address increments the bank. A programmed length of 0 moves 65536 bytes.
- R10: At the end, command bit 7 clears and status bit 6 (end of block) sets. `irq` and status bit 7 go high only if interrupt-enable bit 6 is set.
- R11: A status read (offset 0) returns the flags and then clears bits 7, 6 and 5, and `irq`.
- R12: Register writes during a job are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status clear) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| snoop_wr | input | 1 | CPU bus write observed |
| snoop_addr | input | 16 | Address of the observed CPU write |
| dma_req | output | 1 | Stall request; high while a job owns the buses |
| irq | output | 1 | End-of-block interrupt |
| hb_addr | output | 16 | Host RAM address |
| hb_wr | output | 1 | Host RAM write enable |
| hb_wdata | output | 8 | Host RAM write data |
| hb_rdata | input | 8 | Host RAM read data |
| xr_addr | output | 24 | Expansion RAM address {bank, address} |
| xr_wr | output | 1 | Expansion RAM write enable |
| xr_wdata | output | 8 | Expansion RAM write data |
| xr_rdata | input | 8 | Expansion RAM read data |

## Verification
The hardest state to reach from the ports is a full 65536-byte job whose expansion address crosses a 64K boundary. Here the length register wraps from zero and the bank must step exactly once. A directed compare job programmed with length 0 reaches it, and the bench then checks the stall duration and the read-back bank. Seeded random jobs mix all four types, both hold bits and the interrupt enable over random windows. Directed jobs cover the deferred trigger with a decoy address, a bank carry, and a register write attempted in the middle of a job.

// File: rtl/xdma_pkg.sv
// Shared widths, register offsets, command bit positions and types for the
// expansion RAM block mover. Assumes byte-wide registers and 16-bit counters.
package xdma_pkg;
    localparam int DW    = 8;
    localparam int HAW   = 16;
    localparam int XAW   = 16;
    localparam int BKW   = 8;
    localparam int LENW  = 16;
    localparam int SELW  = 4;
    localparam int XFULL = XAW + BKW;

    localparam int OFS_STAT = 0;
    localparam int OFS_CMD  = 1;
    localparam int OFS_HLO  = 2;
    localparam int OFS_HHI  = 3;
    localparam int OFS_XLO  = 4;
    localparam int OFS_XHI  = 5;
    localparam int OFS_BANK = 6;
    localparam int OFS_LLO  = 7;
    localparam int OFS_LHI  = 8;
    localparam int OFS_IEN  = 9;
    localparam int OFS_HOLD = 10;

    localparam int CMD_EXEC = 7;
    localparam int CMD_NOW  = 4;
    localparam int IEN_EOB  = 6;
    localparam int HOLD_H   = 7;
    localparam int HOLD_X   = 6;

    typedef enum logic [1:0] {
        XT_TO_XRAM = 2'b00,
        XT_TO_HOST = 2'b01,
        XT_SWAP    = 2'b10,
        XT_CMP     = 2'b11
    } xfer_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BUSY  = 2'd2
    } eng_state_e;
endpackage

// File: rtl/xdma_regs.sv
// Register window, live address/length counters and status flags.
// Assumes the sequencer asserts step on every busy cycle and last on the
// final one; writes are refused while busy.
module xdma_regs
    import xdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic [SELW-1:0]  sel,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic             busy,
    input  logic             step,
    input  logic             last,
    input  logic             mism_hit,
    output logic             cmd_wr,
    output logic [DW-1:0]    cmd_q,
    output logic [HAW-1:0]   haddr,
    output logic [XAW-1:0]   xaddr,
    output logic [BKW-1:0]   bank,
    output logic [LENW-1:0]  len,
    output logic [DW-1:0]    ien,
    output logic [DW-1:0]    hold,
    output logic             irq
);
    logic wr_ok;
    logic stat_rd;
    logic eob_q;
    logic mism_q;
    logic done;

    assign wr_ok   = wr && !busy;
    assign cmd_wr  = wr_ok && (sel == SELW'(OFS_CMD));
    assign stat_rd = rd && (sel == SELW'(OFS_STAT));
    assign done    = step && last;

    // Configuration registers: CPU writes when idle, counter updates when busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            haddr <= '0;
            xaddr <= '0;
            bank  <= '0;
            len   <= '0;
            ien   <= '0;
            hold  <= '0;
        end else if (wr_ok) begin
            case (sel)
                SELW'(OFS_CMD):  cmd_q         <= wdata;
                SELW'(OFS_HLO):  haddr[7:0]    <= wdata;
                SELW'(OFS_HHI):  haddr[15:8]   <= wdata;
                SELW'(OFS_XLO):  xaddr[7:0]    <= wdata;
                SELW'(OFS_XHI):  xaddr[15:8]   <= wdata;
                SELW'(OFS_BANK): bank          <= wdata;
                SELW'(OFS_LLO):  len[7:0]      <= wdata;
                SELW'(OFS_LHI):  len[15:8]     <= wdata;
                SELW'(OFS_IEN):  ien           <= wdata;
                SELW'(OFS_HOLD): hold          <= wdata;
                default: ;
            endcase
        end else if (step) begin
            if (!hold[HOLD_H]) haddr <= haddr + HAW'(1);
            if (!hold[HOLD_X]) {bank, xaddr} <= {bank, xaddr} + XFULL'(1);
            if (!last) len <= len - LENW'(1);
            else       cmd_q[CMD_EXEC] <= 1'b0;
        end
    end

    // Status flags: a read clears them, and new events in the same cycle win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eob_q  <= 1'b0;
            mism_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (stat_rd) begin
                eob_q  <= 1'b0;
                mism_q <= 1'b0;
                irq    <= 1'b0;
            end
            if (mism_hit) mism_q <= 1'b1;
            if (done) begin
                eob_q <= 1'b1;
                if (ien[IEN_EOB]) irq <= 1'b1;
            end
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (sel)
            SELW'(OFS_STAT): rdata = {irq, eob_q, mism_q, 5'b0};
            SELW'(OFS_CMD):  rdata = cmd_q;
            SELW'(OFS_HLO):  rdata = haddr[7:0];
            SELW'(OFS_HHI):  rdata = haddr[15:8];
            SELW'(OFS_XLO):  rdata = xaddr[7:0];
            SELW'(OFS_XHI):  rdata = xaddr[15:8];
            SELW'(OFS_BANK): rdata = bank;
            SELW'(OFS_LLO):  rdata = len[7:0];
            SELW'(OFS_LHI):  rdata = len[15:8];
            SELW'(OFS_IEN):  rdata = ien;
            SELW'(OFS_HOLD): rdata = hold;
            default:         rdata = '0;
        endcase
    end
endmodule

// File: rtl/xdma_seq.sv
// Job sequencer: idle, armed (waiting for the trigger write) and busy.
// Assumes the length counter holds the remaining byte count, 0 meaning 65536.
module xdma_seq
    import xdma_pkg::*;
#(
    parameter logic [HAW-1:0] TRIG_ADDR = 16'hFF00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [DW-1:0]    cmd_wdata,
    input  logic             snoop_wr,
    input  logic [HAW-1:0]   snoop_addr,
    input  logic [LENW-1:0]  len,
    output logic             busy,
    output logic             step,
    output logic             last
);
    eng_state_e st_q, st_d;
    logic       trig_hit;

    assign trig_hit = snoop_wr && (snoop_addr == TRIG_ADDR);
    assign busy     = (st_q == ST_BUSY);
    assign step     = busy;
    assign last     = busy && (len == LENW'(1));

    // Next-state decision.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE, ST_ARMED: begin
                if (cmd_wr) begin
                    if (!cmd_wdata[CMD_EXEC])     st_d = ST_IDLE;
                    else if (cmd_wdata[CMD_NOW])  st_d = ST_BUSY;
                    else                          st_d = ST_ARMED;
                end else if (st_q == ST_ARMED && trig_hit) begin
                    st_d = ST_BUSY;
                end
            end
            ST_BUSY: if (last) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/xdma_path.sv
// Byte datapath: steers read data to the opposite memory according to the
// transfer type and flags compare mismatches. Assumes both memories return
// read data in the same cycle as the address.
module xdma_path
    import xdma_pkg::*;
(
    input  logic             busy,
    input  logic [1:0]       xtype,
    input  logic [HAW-1:0]   haddr,
    input  logic [XAW-1:0]   xaddr,
    input  logic [BKW-1:0]   bank,
    input  logic [DW-1:0]    hb_rdata,
    input  logic [DW-1:0]    xr_rdata,
    output logic [HAW-1:0]   hb_addr,
    output logic             hb_wr,
    output logic [DW-1:0]    hb_wdata,
    output logic [XFULL-1:0] xr_addr,
    output logic             xr_wr,
    output logic [DW-1:0]    xr_wdata,
    output logic             mism_hit
);
    assign hb_addr  = haddr;
    assign xr_addr  = {bank, xaddr};
    assign hb_wdata = xr_rdata;
    assign xr_wdata = hb_rdata;

    // Write enables and compare result per transfer type.
    always_comb begin
        hb_wr    = 1'b0;
        xr_wr    = 1'b0;
        mism_hit = 1'b0;
        if (busy) begin
            case (xfer_e'(xtype))
                XT_TO_XRAM: xr_wr = 1'b1;
                XT_TO_HOST: hb_wr = 1'b1;
                XT_SWAP: begin
                    xr_wr = 1'b1;
                    hb_wr = 1'b1;
                end
                XT_CMP:  mism_hit = (hb_rdata != xr_rdata);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xram_dma.sv
// Top of the expansion RAM block mover: register window, sequencer and
// datapath. Assumes single-cycle memories and a CPU that honours dma_req.
module xram_dma
    import xdma_pkg::*;
#(
    parameter logic [15:0] TRIG_ADDR = 16'hFF00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        snoop_wr,
    input  logic [15:0] snoop_addr,
    output logic        dma_req,
    output logic        irq,
    output logic [15:0] hb_addr,
    output logic        hb_wr,
    output logic [7:0]  hb_wdata,
    input  logic [7:0]  hb_rdata,
    output logic [23:0] xr_addr,
    output logic        xr_wr,
    output logic [7:0]  xr_wdata,
    input  logic [7:0]  xr_rdata
);
    logic            busy, step, last, mism_hit, cmd_wr;
    logic [DW-1:0]   cmd_q, ien, hold;
    logic [HAW-1:0]  haddr;
    logic [XAW-1:0]  xaddr;
    logic [BKW-1:0]  bank;
    logic [LENW-1:0] len;
    logic [15:0]     hb_addr_w;
    logic [23:0]     xr_addr_w;
    logic            hb_wr_w, xr_wr_w;
    logic [7:0]      hb_wdata_w, xr_wdata_w;
    logic [7:0]      rdata_w;
    logic            irq_w;

    assign dma_req   = busy;
    assign reg_rdata = rdata_w;
    assign irq       = irq_w;
    assign hb_addr   = hb_addr_w;
    assign hb_wr     = hb_wr_w;
    assign hb_wdata  = hb_wdata_w;
    assign xr_addr   = xr_addr_w;
    assign xr_wr     = xr_wr_w;
    assign xr_wdata  = xr_wdata_w;

    xdma_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(rdata_w), .busy(busy), .step(step),
        .last(last), .mism_hit(mism_hit), .cmd_wr(cmd_wr), .cmd_q(cmd_q),
        .haddr(haddr), .xaddr(xaddr), .bank(bank), .len(len), .ien(ien),
        .hold(hold), .irq(irq_w)
    );

    xdma_seq #(.TRIG_ADDR(TRIG_ADDR)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(reg_wdata),
        .snoop_wr(snoop_wr), .snoop_addr(snoop_addr), .len(len),
        .busy(busy), .step(step), .last(last)
    );

    xdma_path u_path (
        .busy(busy), .xtype(cmd_q[1:0]), .haddr(haddr), .xaddr(xaddr),
        .bank(bank), .hb_rdata(hb_rdata), .xr_rdata(xr_rdata),
        .hb_addr(hb_addr_w), .hb_wr(hb_wr_w), .hb_wdata(hb_wdata_w),
        .xr_addr(xr_addr_w), .xr_wr(xr_wr_w), .xr_wdata(xr_wdata_w),
        .mism_hit(mism_hit)
    );
endmodule

// File: rtl/xdma_checker.sv
// Temporal properties of the block mover, bound into the top module.
// Assumes the bound signals keep their names in the top scope.
module xdma_checker #(
    parameter logic [15:0] TRIG = 16'hFF00
) (
    input logic        clk,
    input logic        rst_n,
    input logic        dma_req,
    input logic        irq,
    input logic        hb_wr,
    input logic        xr_wr,
    input logic [15:0] hb_addr,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [3:0]  reg_sel,
    input logic        snoop_wr,
    input logic [15:0] snoop_addr,
    input logic [7:0]  cmd_q,
    input logic [7:0]  hold,
    input logic [15:0] len
);
    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_req |-> (!hb_wr && !xr_wr)); // R5
    AST_CMP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && cmd_q[1:0] == 2'b11) |-> (!hb_wr && !xr_wr)); // R7
    AST_LEN_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && $past(dma_req)) |-> (len == 16'($past(len) - 16'd1))); // R3
    AST_HOST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && $past(dma_req) && hold[7]) |-> $stable(hb_addr)); // R8
    AST_EXEC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_req) |-> !cmd_q[7]); // R10
    AST_IRQ_AFTER_JOB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(dma_req)); // R10
    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> ($past(reg_wr) || $past(snoop_wr && snoop_addr == TRIG))); // R4
    AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && reg_sel == 4'd0 && !dma_req) |-> !irq); // R11
endmodule

bind xram_dma xdma_checker #(.TRIG(TRIG_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .irq(irq), .hb_wr(hb_wr),
    .xr_wr(xr_wr), .hb_addr(hb_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .snoop_wr(snoop_wr), .snoop_addr(snoop_addr),
    .cmd_q(cmd_q), .hold(hold), .len(len)
);

// File: tb/test_xram_dma.sv
module test_xram_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0, reg_rdata;
    logic        snoop_wr = 1'b0;
    logic [15:0] snoop_addr = '0;
    logic        dma_req, irq, hb_wr, xr_wr;
    logic [15:0] hb_addr;
    logic [23:0] xr_addr;
    logic [7:0]  hb_wdata, hb_rdata, xr_wdata, xr_rdata;

    logic [7:0] hmem [4096];
    logic [7:0] xmem [4096];
    logic [7:0] eh   [4096];
    logic [7:0] ex   [4096];
    int total = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    xram_dma i_xram_dma (.*);

    assign hb_rdata = hmem[hb_addr[11:0]];
    assign xr_rdata = xmem[xr_addr[11:0]];
    always @(posedge clk) begin
        if (hb_wr) hmem[hb_addr[11:0]] <= hb_wdata;
        if (xr_wr) xmem[xr_addr[11:0]] <= xr_wdata;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rwr(input int sel, input int d);
        @(negedge clk);
        reg_sel = 4'(sel); reg_wdata = 8'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rrd(input int sel, output int d);
        @(negedge clk);
        reg_sel = 4'(sel); reg_rd = 1'b1;
        #1 d = int'(reg_rdata);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic snoop(input int a);
        @(negedge clk);
        snoop_addr = 16'(a); snoop_wr = 1'b1;
        @(negedge clk);
        snoop_wr = 1'b0;
    endtask

    function automatic int mem_diffs();
        int n = 0;
        for (int i = 0; i < 4096; i++) begin
            if (hmem[i] !== eh[i]) n++;
            if (xmem[i] !== ex[i]) n++;
        end
        return n;
    endfunction

    // Reference job over the expected memories; returns the mismatch flag.
    function automatic bit ref_job(int ha, int xa, int bk, int ln, int ty, bit fh, bit fx);
        bit mm = 0;
        logic [7:0] t;
        for (int i = 0; i < ln; i++) begin
            int h = (fh ? ha : ha + i) & 16'hFFF;
            int x = (fx ? xa : xa + i) & 16'hFFF;
            case (ty)
                0: ex[x] = eh[h];
                1: eh[h] = ex[x];
                2: begin t = eh[h]; eh[h] = ex[x]; ex[x] = t; end
                default: if (eh[h] != ex[x]) mm = 1;
            endcase
        end
        return mm;
    endfunction

    task automatic job(input int ha, input int xa, input int bk, input int ln,
                       input int ty, input bit fh, input bit fx, input bit ie, input bit defer);
        int n = 0, d, lim = 0;
        bit mm;
        int xend;
        int regs[11];
        regs[2] = ha & 255; regs[3] = (ha >> 8) & 255;
        regs[4] = xa & 255; regs[5] = (xa >> 8) & 255; regs[6] = bk;
        regs[7] = ln & 255; regs[8] = (ln >> 8) & 255;
        regs[9] = ie ? 8'h40 : 8'h00; regs[10] = {fh, fx, 6'b0};
        for (int k = 2; k <= 10; k++) rwr(k, regs[k]);
        mm = ref_job(ha, xa, bk, ln, ty, fh, fx);
        if (defer) begin
            rwr(1, 8'h80 | ty);
            repeat (3) @(negedge clk);
            check(dma_req == 1'b0, "R4 waits for trigger", dma_req, 0);
            snoop(16'hFE00);
            check(dma_req == 1'b0, "R4 decoy address ignored", dma_req, 0);
            snoop(16'hFF00);
        end else begin
            rwr(1, 8'h90 | ty);
        end
        while (dma_req && lim < 70000) begin n++; lim++; @(negedge clk); end
        check(n == ln, "R3 stall cycles equal length", n, ln);
        d = mem_diffs();
        check(d == 0, ty == 2 ? "R6 swap contents" : ty == 3 ? "R7 compare writes nothing" : "R5 copy contents", d, 0);
        check(irq == ie, "R10 irq follows enable", irq, ie);
        rrd(0, d);
        check(d == {ie, 1'b1, mm, 5'b0}, "R10 R7 status flags", d, {ie, 1'b1, mm, 5'b0});
        rrd(0, d);
        check(d == 0 && irq == 0, "R11 status cleared by read", d, 0);
        rrd(1, d);
        check(d == (defer ? ty : 8'h10 | ty), "R10 execute bit cleared", d, defer ? ty : 8'h10 | ty);
        rrd(2, d); n = d; rrd(3, d); n |= d << 8;
        check(n == ((fh ? ha : ha + ln) & 16'hFFFF), "R8 host address advance", n, (fh ? ha : ha + ln) & 16'hFFFF);
        xend = fx ? ((bk << 16) | xa) : (((bk << 16) | xa) + ln) & 24'hFFFFFF;
        rrd(4, d); n = d; rrd(5, d); n |= d << 8; rrd(6, d); n |= d << 16;
        check(n == xend, "R9 R8 expansion address and bank", n, xend);
        rrd(7, d); n = d; rrd(8, d); n |= d << 8;
        check(n == 1, "R3 length ends at one", n, 1);
    endtask

    initial begin
        int d, ha, xa, ln, ty, lim;
        void'($urandom(32'd2718));
        for (int i = 0; i < 4096; i++) begin
            hmem[i] = 8'($urandom); xmem[i] = 8'($urandom);
            eh[i] = hmem[i]; ex[i] = xmem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(dma_req == 0 && irq == 0, "R1 outputs low after reset", {dma_req, irq}, 0);
        for (int k = 0; k <= 10; k++) begin
            rrd(k, d);
            check(d == 0, "R1 register resets to zero", d, 0);
        end
        // R2 read-back, command without execute starts nothing
        for (int k = 2; k <= 10; k++) rwr(k, 8'h11 * k);
        rwr(1, 8'h13);
        check(dma_req == 0, "R2 command without execute idle", dma_req, 0);
        rrd(1, d);
        check(d == 8'h13, "R2 command read-back", d, 8'h13);
        for (int k = 2; k <= 10; k++) begin
            rrd(k, d);
            check(d == ((8'h11 * k) & 255), "R2 register read-back", d, (8'h11 * k) & 255);
        end
        // Directed: each type, deferred start, bank carry
        job(16'h0100, 16'h0200, 8'h00, 8,  0, 0, 0, 1, 0);
        job(16'h0300, 16'h0400, 8'h01, 8,  1, 0, 0, 0, 0);
        job(16'h0500, 16'h0600, 8'h02, 5,  2, 0, 0, 1, 0);
        job(16'h0700, 16'h0800, 8'h00, 6,  1, 0, 0, 1, 1);
        job(16'h0900, 16'hFFFE, 8'h03, 4,  0, 0, 0, 0, 0);
        job(16'h0A00, 16'h0B00, 8'h00, 7,  1, 1, 0, 1, 0);
        job(16'h0C00, 16'h0D00, 8'h00, 7,  0, 0, 1, 0, 0);
        // R12 register write during a job is ignored
        for (int k = 2; k <= 10; k++) rwr(k, 0);
        rwr(7, 20); rwr(3, 8'h0E);
        ex[0:19] = xmem[0:19];
        for (int i = 0; i < 20; i++) eh[16'hE00 + i] = ex[i];
        rwr(1, 8'h91);
        rwr(7, 8'h55);
        lim = 0;
        while (dma_req && lim < 100) begin lim++; @(negedge clk); end
        rrd(7, d);
        check(d == 1, "R12 length write during job ignored", d, 1);
        check(mem_diffs() == 0, "R12 job completes intact", mem_diffs(), 0);
        rrd(0, d);
        // Seeded random jobs
        for (int r = 0; r < 24; r++) begin
            ha = $urandom_range(0, 3800); xa = $urandom_range(0, 3800);
            ln = $urandom_range(1, 48); ty = $urandom_range(0, 3);
            if (ty == 3 && $urandom_range(0, 1) == 1)
                for (int i = 0; i < ln; i++) begin
                    hmem[(ha + i) & 12'hFFF] = xmem[(xa + i) & 12'hFFF];
                    eh[(ha + i) & 12'hFFF] = xmem[(xa + i) & 12'hFFF];
                end
            job(ha, xa, $urandom_range(0, 255), ln, ty,
                $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0);
        end
        // R9 length 0 means 65536 bytes; expansion address wraps into the bank
        job(16'h0000, 16'h0123, 8'h07, 65536, 3, 0, 0, 1, 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog expired", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule